// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers 64 interrupt request lines and turns them into two processor-facing interrupt outputs: a fast line and a normal line. A rising edge on a request line latches a pending bit. Per-source enable bits gate the pending bits, and a 3-bit priority per source decides two things: which output line the source drives, and which source wins arbitration. Software reaches every register through a single-cycle 32-bit read/write port with an 8-bit byte offset.

The arbiter picks the most urgent candidate source. Software reads an entry word equal to a programmable base plus four times the winning source number plus one. With a base of zero, the handler recovers the source as entry/4 - 1. An entry word equal to the base alone means there is no candidate.

A control bit selects the candidate set for the entry word. When it is clear, only enabled pending sources compete, so masking a source removes it from the entry at once. When it is set, masked pending sources also compete. The output lines are registered.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, both enable words, the control word, the base and all pending bits read 0. Every priority field reads 7, the entry word reads 0, and both output lines are low.
- R2: A 0-to-1 transition on a request line sets that source's pending bit at the next clock edge. A request held high does not set the bit again after it has been cleared.
- R3: Writing 1 to a bit of any status word (0x00, 0x04, 0x08, 0x0C) clears the pending bit of that source. Writing 0 leaves the bit unchanged.
- R4: If a rising request edge and a write-1 clear for the same source fall in the same cycle, the pending bit stays set.
- R5: Source n lives in bank n/32 at bit n%32. Bank 0 status is at 0x00/0x08 and its enable at 0x18. Bank 1 status is at 0x04/0x0C and its enable at 0x1C. An enable bit of 1 unmasks the source.
- R6: Priority word k, at offset 0x30+4k for k in 0..7, holds source 8k+j in bits 4j+2..4j. Bit 4j+3 always reads 0.
- R7: The entry word at 0x28 reads base + 4*(s+1), where s is the candidate with the lowest priority value. Among equal priority values, the lowest source number wins. The base is written at 0x24.
- R8: With no candidate source, the entry word reads the base alone.
- R9: Control bit 0 at 0x20 selects the candidate set. When it is 0, candidates are pending and enabled sources, so clearing an enable bit removes the source from the entry at once. When it is 1, candidates are all pending sources, masked or not.
- R10: The fast status words (0x00/0x04) show pending sources whose priority is 0 or 1. The normal status words (0x08/0x0C) show the other pending sources. The fast output goes high one clock after any enabled pending source with priority 0 or 1 exists, and the normal output does the same for the other priorities.
- R11: Reads of any unaligned offset, or of any offset not named above, return 0. Writes to them change nothing. The entry word is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req_i | input | 64 | Request lines, one per source |
| bus_sel_i | input | 1 | Register port access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the same cycle as the strobe |
| fast_irq_o | output | 1 | Registered fast interrupt line |
| norm_irq_o | output | 1 | Registered normal interrupt line |

## Verification
A new request edge and a software write-1 acknowledge of the same source can land in one cycle. The bench first latches and drops a request. Then, on one edge, it raises the request again while writing 1 to that source's status bit. It judges the outcome by reading back the status word, which must still show the bit set. A later acknowledge with the line held high must clear it for good.

// File: rtl/irq_ctrl_pkg.sv
`timescale 1ns/1ps
package irq_ctrl_pkg;

    localparam int unsigned SRC_N     = 64;
    localparam int unsigned OFS_W     = 8;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned FIELD_W   = 4;
    localparam int unsigned PER_WORD  = WORD_W / FIELD_W;

    typedef enum logic [3:0] {
        RS_NONE,
        RS_FST0,
        RS_FST1,
        RS_NRM0,
        RS_NRM1,
        RS_ENA0,
        RS_ENA1,
        RS_CTRL,
        RS_BASE,
        RS_ENTRY,
        RS_PRIO
    } reg_sel_e;

    function automatic reg_sel_e decode_ofs(input logic [OFS_W-1:0] ofs);
        reg_sel_e s;
        s = RS_NONE;
        if (ofs[1:0] == 2'b00) begin
            case (ofs[OFS_W-1:2])
                6'h00: s = RS_FST0;
                6'h01: s = RS_FST1;
                6'h02: s = RS_NRM0;
                6'h03: s = RS_NRM1;
                6'h06: s = RS_ENA0;
                6'h07: s = RS_ENA1;
                6'h08: s = RS_CTRL;
                6'h09: s = RS_BASE;
                6'h0A: s = RS_ENTRY;
                6'h0C, 6'h0D, 6'h0E, 6'h0F,
                6'h10, 6'h11, 6'h12, 6'h13: s = RS_PRIO;
                default: s = RS_NONE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/irq_pend_latch.sv
`timescale 1ns/1ps
module irq_pend_latch #(
    parameter int unsigned N_SRC = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req_i,
    input  logic [N_SRC-1:0] clr_i,
    output logic [N_SRC-1:0] pend_o
);

    logic [N_SRC-1:0] req_q;
    logic [N_SRC-1:0] pend_q;
    logic [N_SRC-1:0] rise;

    assign rise   = req_i & ~req_q;
    assign pend_o = pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= '0;
            pend_q <= '0;
        end else begin
            req_q  <= req_i;
            pend_q <= (pend_q & ~clr_i) | rise;
        end
    end

    // R2
    edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((pend_q & $past(rise)) == $past(rise)));

    // R3
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~rise)) |=> ((pend_q & $past(clr_i & ~rise)) == '0));

    // R4
    edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & rise)) |=> ((pend_q & $past(clr_i & rise)) == $past(clr_i & rise)));

endmodule

// File: rtl/irq_prio_arb.sv
`timescale 1ns/1ps
module irq_prio_arb #(
    parameter int unsigned N_SRC  = 64,
    parameter int unsigned PRIO_W = 3,
    localparam int unsigned IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]        cand_i,
    input  logic [N_SRC*PRIO_W-1:0] prio_i,
    output logic                    valid_o,
    output logic [IDX_W-1:0]        win_o
);

    logic [PRIO_W-1:0] best_p;

    // Scan from the top index down so that on a tie the lower index replaces the higher.
    always_comb begin
        valid_o = 1'b0;
        win_o   = '0;
        best_p  = '1;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (cand_i[i] && (!valid_o || (prio_i[i*PRIO_W +: PRIO_W] <= best_p))) begin
                valid_o = 1'b1;
                best_p  = prio_i[i*PRIO_W +: PRIO_W];
                win_o   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_regs.sv
`timescale 1ns/1ps
module irq_regs
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned N_SRC    = 64,
    parameter int unsigned PRIO_W   = 3,
    parameter int unsigned PRIO_RST = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_i,
    input  reg_sel_e                sel_i,
    input  logic [2:0]              pidx_i,
    input  logic [WORD_W-1:0]       wdata_i,
    output logic [N_SRC-1:0]        en_o,
    output logic                    show_masked_o,
    output logic [WORD_W-1:0]       base_o,
    output logic [N_SRC*PRIO_W-1:0] prio_o,
    output logic [N_SRC-1:0]        clr_o
);

    localparam logic [PRIO_W-1:0] PRST = PRIO_W'(PRIO_RST);
    localparam int unsigned HALF = N_SRC / 2;

    logic [N_SRC-1:0]        en_q;
    logic                    show_q;
    logic [WORD_W-1:0]       base_q;
    logic [N_SRC*PRIO_W-1:0] prio_q;

    assign en_o          = en_q;
    assign show_masked_o = show_q;
    assign base_o        = base_q;
    assign prio_o        = prio_q;

    always_comb begin
        clr_o = '0;
        if (wr_i) begin
            unique case (sel_i)
                RS_FST0, RS_NRM0: clr_o[HALF-1:0]     = wdata_i[HALF-1:0];
                RS_FST1, RS_NRM1: clr_o[N_SRC-1:HALF] = wdata_i[HALF-1:0];
                default:          clr_o = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            show_q <= 1'b0;
            base_q <= '0;
            prio_q <= {N_SRC{PRST}};
        end else if (wr_i) begin
            unique case (sel_i)
                RS_ENA0: en_q[HALF-1:0]     <= wdata_i[HALF-1:0];
                RS_ENA1: en_q[N_SRC-1:HALF] <= wdata_i[HALF-1:0];
                RS_CTRL: show_q             <= wdata_i[0];
                RS_BASE: base_q             <= wdata_i;
                RS_PRIO: begin
                    for (int j = 0; j < PER_WORD; j++) begin
                        prio_q[(int'(pidx_i)*PER_WORD + j)*PRIO_W +: PRIO_W]
                            <= wdata_i[j*FIELD_W +: PRIO_W];
                    end
                end
                default: ;
            endcase
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (en_q == '0 && base_q == '0 && !show_q));

    // R11
    dead_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && (sel_i == RS_NONE || sel_i == RS_ENTRY)) |=>
            ($stable(en_q) && $stable(base_q) && $stable(prio_q) && $stable(show_q)));

endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned PRIO_W   = 3,
    parameter int unsigned FAST_MAX = 1,
    parameter int unsigned PRIO_RST = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  irq_req_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [OFS_W-1:0]  bus_addr_i,
    input  logic [WORD_W-1:0] bus_wdata_i,
    output logic [WORD_W-1:0] bus_rdata_o,
    output logic              fast_irq_o,
    output logic              norm_irq_o
);

    localparam int unsigned N_SRC = SRC_N;
    localparam int unsigned IDX_W = $clog2(N_SRC);
    localparam int unsigned HALF  = N_SRC / 2;

    reg_sel_e                sel;
    logic [2:0]              pidx;
    logic                    wr;
    logic [N_SRC-1:0]        en, pend, clr, is_fast, cand;
    logic                    show_masked;
    logic [WORD_W-1:0]       base, entry;
    logic [N_SRC*PRIO_W-1:0] prio;
    logic                    win_valid;
    logic [IDX_W-1:0]        win;
    logic                    fast_q, norm_q;

    assign sel  = decode_ofs(bus_addr_i);
    assign pidx = 3'(bus_addr_i[4:2] - 3'd4);
    assign wr   = bus_sel_i & bus_wr_i;

    irq_regs #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .PRIO_RST(PRIO_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(wr), .sel_i(sel), .pidx_i(pidx),
        .wdata_i(bus_wdata_i), .en_o(en), .show_masked_o(show_masked),
        .base_o(base), .prio_o(prio), .clr_o(clr)
    );

    irq_pend_latch #(.N_SRC(N_SRC)) u_pend (
        .clk(clk), .rst_n(rst_n), .req_i(irq_req_i), .clr_i(clr), .pend_o(pend)
    );

    for (genvar g = 0; g < N_SRC; g++) begin : g_route
        assign is_fast[g] = (prio[g*PRIO_W +: PRIO_W] <= PRIO_W'(FAST_MAX));
    end

    assign cand = show_masked ? pend : (pend & en);

    irq_prio_arb #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
        .cand_i(cand), .prio_i(prio), .valid_o(win_valid), .win_o(win)
    );

    assign entry = win_valid ? (base + ((WORD_W'(win) + WORD_W'(1)) << 2)) : base;

    always_comb begin
        bus_rdata_o = '0;
        if (bus_sel_i) begin
            unique case (sel)
                RS_FST0:  bus_rdata_o = WORD_W'(pend[HALF-1:0] & is_fast[HALF-1:0]);
                RS_FST1:  bus_rdata_o = WORD_W'(pend[N_SRC-1:HALF] & is_fast[N_SRC-1:HALF]);
                RS_NRM0:  bus_rdata_o = WORD_W'(pend[HALF-1:0] & ~is_fast[HALF-1:0]);
                RS_NRM1:  bus_rdata_o = WORD_W'(pend[N_SRC-1:HALF] & ~is_fast[N_SRC-1:HALF]);
                RS_ENA0:  bus_rdata_o = WORD_W'(en[HALF-1:0]);
                RS_ENA1:  bus_rdata_o = WORD_W'(en[N_SRC-1:HALF]);
                RS_CTRL:  bus_rdata_o = WORD_W'(show_masked);
                RS_BASE:  bus_rdata_o = base;
                RS_ENTRY: bus_rdata_o = entry;
                RS_PRIO: begin
                    for (int j = 0; j < PER_WORD; j++) begin
                        bus_rdata_o[j*FIELD_W +: PRIO_W] =
                            prio[(int'(pidx)*PER_WORD + j)*PRIO_W +: PRIO_W];
                    end
                end
                default:  bus_rdata_o = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fast_q <= 1'b0;
            norm_q <= 1'b0;
        end else begin
            fast_q <= |(pend & en & is_fast);
            norm_q <= |(pend & en & ~is_fast);
        end
    end

    assign fast_irq_o = fast_q;
    assign norm_irq_o = norm_q;

    // R10
    fast_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fast_irq_o |-> $past(|(pend & en & is_fast)));

    // R10
    norm_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        norm_irq_o |-> $past(|(pend & en & ~is_fast)));

    // R8
    empty_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cand == '0) |-> (entry == base));

    for (genvar g = 0; g < N_SRC; g++) begin : g_arb_chk
        // R7
        winner_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (win_valid && cand[g]) |->
                (prio[int'(win)*PRIO_W +: PRIO_W] < prio[g*PRIO_W +: PRIO_W] ||
                 (prio[int'(win)*PRIO_W +: PRIO_W] == prio[g*PRIO_W +: PRIO_W] &&
                  int'(win) <= g)));
    end

endmodule

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        fast_o, norm_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    prio_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_req_i(src), .bus_sel_i(sel),
        .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .fast_irq_o(fast_o), .norm_irq_o(norm_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1;
        chk(tag, rdata, exp);
        sel = 1'b0;
    endtask

    task automatic pulse(input int idx);
        @(negedge clk);
        src[idx] = 1'b1;
        @(negedge clk);
        src[idx] = 1'b0;
    endtask

    task automatic t_reset;
        rd_chk("R1 en0", 8'h18, 32'h0);
        rd_chk("R1 en1", 8'h1C, 32'h0);
        rd_chk("R1 ctrl", 8'h20, 32'h0);
        rd_chk("R1 base", 8'h24, 32'h0);
        rd_chk("R1 prio0", 8'h30, 32'h77777777);
        rd_chk("R1 prio7", 8'h4C, 32'h77777777);
        rd_chk("R1 entry", 8'h28, 32'h0);
        rd_chk("R1 nrm0", 8'h08, 32'h0);
        chk("R1 fast line", 32'(fast_o), 32'h0);
        chk("R1 norm line", 32'(norm_o), 32'h0);
    endtask

    task automatic t_edge_clear;
        bus_write(8'h24, 32'h1000);
        @(negedge clk); src[5] = 1'b1;
        @(negedge clk);
        rd_chk("R2 edge sets pending", 8'h08, 32'h20);
        rd_chk("R10 prio7 not in fast status", 8'h00, 32'h0);
        rd_chk("R9 masked not in entry", 8'h28, 32'h1000);
        bus_write(8'h18, 32'h20);
        rd_chk("R7 entry src5", 8'h28, 32'h1018);
        @(negedge clk);
        chk("R10 norm line", 32'(norm_o), 32'h1);
        chk("R10 fast line low", 32'(fast_o), 32'h0);
        bus_write(8'h08, 32'h0);
        rd_chk("R3 write0 keeps", 8'h08, 32'h20);
        bus_write(8'h08, 32'h20);
        rd_chk("R3 write1 clears, R2 held level", 8'h08, 32'h0);
        @(negedge clk);
        chk("R10 norm line drops", 32'(norm_o), 32'h0);
        src[5] = 1'b0;
        rd_chk("R8 empty entry", 8'h28, 32'h1000);
    endtask

    task automatic t_bank;
        pulse(40);
        rd_chk("R5 bank1 status", 8'h0C, 32'h100);
        rd_chk("R5 bank0 untouched", 8'h08, 32'h0);
        bus_write(8'h1C, 32'h100);
        rd_chk("R5 en1", 8'h1C, 32'h100);
        rd_chk("R5 en0 kept", 8'h18, 32'h20);
        rd_chk("R7 entry src40", 8'h28, 32'h10A4);
    endtask

    task automatic t_prio;
        bus_write(8'h44, 32'hFFFFFFF0);
        rd_chk("R6 reserved bits zero", 8'h44, 32'h77777770);
        rd_chk("R10 fast status bank1", 8'h04, 32'h100);
        rd_chk("R10 normal status bank1", 8'h0C, 32'h0);
        @(negedge clk);
        chk("R10 fast line", 32'(fast_o), 32'h1);
        chk("R10 norm line off", 32'(norm_o), 32'h0);
        bus_write(8'h04, 32'h100);
        @(negedge clk);
        chk("R3 fast clear drops line", 32'(fast_o), 32'h0);
    endtask

    task automatic t_arb;
        bus_write(8'h18, 32'hFFFFFFFF);
        bus_write(8'h1C, 32'hFFFFFFFF);
        bus_write(8'h30, 32'h77772777);
        bus_write(8'h34, 32'h77777727);
        bus_write(8'h4C, 32'h77727777);
        rd_chk("R6 prio1 readback", 8'h34, 32'h77777727);
        @(negedge clk);
        src[3] = 1'b1; src[9] = 1'b1; src[60] = 1'b1;
        @(negedge clk);
        src[3] = 1'b0; src[9] = 1'b0; src[60] = 1'b0;
        rd_chk("R7 tie lowest number", 8'h28, 32'h1010);
        bus_write(8'h08, 32'h8);
        rd_chk("R7 next tie", 8'h28, 32'h1028);
        bus_write(8'h08, 32'h200);
        rd_chk("R7 bank1 winner", 8'h28, 32'h10F4);
        bus_write(8'h48, 32'h77777177);
        pulse(50);
        rd_chk("R7 lower value beats number", 8'h28, 32'h10CC);
        rd_chk("R10 prio1 fast status", 8'h04, 32'h40000);
        bus_write(8'h04, 32'h40000);
        bus_write(8'h0C, 32'h10000000);
        rd_chk("R8 empty again", 8'h28, 32'h1000);
    endtask

    task automatic t_mode;
        bus_write(8'h18, 32'h0);
        pulse(3);
        pulse(60);
        rd_chk("R9 mode0 skips masked", 8'h28, 32'h10F4);
        bus_write(8'h20, 32'h1);
        rd_chk("R9 ctrl readback", 8'h20, 32'h1);
        rd_chk("R9 mode1 includes masked", 8'h28, 32'h1010);
        @(negedge clk);
        chk("R10 norm line mode1", 32'(norm_o), 32'h1);
        bus_write(8'h20, 32'h0);
        rd_chk("R9 mode0 again", 8'h28, 32'h10F4);
        bus_write(8'h1C, 32'h0);
        rd_chk("R9 immediate disable", 8'h28, 32'h1000);
        @(negedge clk);
        chk("R9 line off after mask", 32'(norm_o), 32'h0);
        bus_write(8'h08, 32'hFFFFFFFF);
        bus_write(8'h0C, 32'hFFFFFFFF);
        rd_chk("R3 bulk clear bank0", 8'h08, 32'h0);
        rd_chk("R3 bulk clear bank1", 8'h0C, 32'h0);
    endtask

    task automatic t_same_cycle;
        bus_write(8'h18, 32'h1);
        pulse(0);
        rd_chk("R4 setup pending", 8'h08, 32'h1);
        @(negedge clk);
        src[0] = 1'b1;
        sel = 1'b1; wr = 1'b1; addr = 8'h08; wdata = 32'h1;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
        rd_chk("R4 edge beats clear", 8'h08, 32'h1);
        bus_write(8'h08, 32'h1);
        rd_chk("R4 later clear works", 8'h08, 32'h0);
        src[0] = 1'b0;
    endtask

    task automatic t_unmapped;
        rd_chk("R11 read 0x10", 8'h10, 32'h0);
        rd_chk("R11 read 0x2C", 8'h2C, 32'h0);
        rd_chk("R11 read 0x50", 8'h50, 32'h0);
        rd_chk("R11 read unaligned", 8'h19, 32'h0);
        bus_write(8'h10, 32'hFFFFFFFF);
        bus_write(8'h50, 32'hFFFFFFFF);
        bus_write(8'h1A, 32'hFFFFFFFF);
        bus_write(8'h28, 32'h1234);
        rd_chk("R11 en0 unchanged", 8'h18, 32'h1);
        rd_chk("R11 base unchanged", 8'h24, 32'h1000);
        rd_chk("R11 ctrl unchanged", 8'h20, 32'h0);
        rd_chk("R11 entry read-only", 8'h28, 32'h1000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_edge_clear();
        t_bank();
        t_prio();
        t_arb();
        t_mode();
        t_same_cycle();
        t_unmapped();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule